// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status Register Set

This block takes an asynchronous serial line and assembles each frame into an 8-bit or 9-bit word. The line is resynchronised into the clock domain and then sampled on a free-running sample tick that runs at sixteen times the bit rate. The baud-rate generator is outside the block. Each bit is voted from three samples near its centre. A receive that completes is placed in a holding data register. The block also keeps five sticky flags: word ready, overrun, noise, framing error and parity error.

Software sees three byte-wide registers on a small bus. Reads are combinational on the address. Reads and writes take effect on the clock edge where the strobe is high. A flag only goes away through a two-step sequence: a status read, then a data read. The second step clears only the flags that the status read saw. One interrupt line combines the ready, overrun and parity conditions under their enables.

Top module: `serial_rx_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `irq` is low.
- R2: A frame is one low start bit, then 8 data bits (9 when the word-length bit is set), least significant first, then one stop bit. When the frame completes, the low 8 bits go to the data register at address 1, and the ready flag (status bit 4) is set 13 clocks after the stop bit begins. This latency holds with the tick high on every clock.
- R3: Each bit is the majority of its samples at tick counts 7, 8 and 9 of the bit. If the three samples differ on any bit of the frame, including start and stop, the noise flag (status bit 2) is set. A short pulse outside that window has no effect.
- R4: A low level that reads high at the centre of the start bit is a false start. The receiver returns to idle and no register changes.
- R5: A stop bit voted low sets the framing flag (status bit 1). This includes an all-zero break frame, and the word is still stored.
- R6: With parity enabled (control bit 3), the last data bit is the parity bit. It is kept in the word. Control bit 2 selects odd (1) or even (0) parity over all data bits. A mismatch sets the parity flag (status bit 0). With parity disabled, that flag is never set.
- R7: In 9-bit mode (control bit 5), the ninth received bit is readable as control bit 7. A completed 8-bit word sets it to 0. Control bit 6 holds the ninth transmit bit that software writes.
- R8: If a word completes while the ready flag is set, the overrun flag (status bit 3) is set. The data register and control bit 7 keep their old values, and the noise, framing and parity results of the lost word are discarded.
- R9: A data read clears only the flags captured by the immediately preceding status read (address 0). A data read without that status read changes nothing, and a flag set between the two reads survives.
- R10: `irq` is high when (control bit 0 and (ready or overrun)) or (control bit 1 and parity error). Noise and framing never raise it.
- R11: Writes reach only the control register (address 2). Bit 7 is read-only, bit 4 reads zero, writes to addresses 0, 1 and 3 are ignored, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | Oversampling strobe, 16 per bit |
| rxd | input | 1 | Asynchronous serial input, idle high |
| bus_addr | input | 2 | Register address: 0 status, 1 data, 2 control |
| bus_rd | input | 1 | Read strobe, acts on the addressed register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: a 16-tick bit and a two-stage input synchroniser, with the tick held high. Each bit then lasts exactly sixteen clocks, so the bench knows which clock feeds each majority sample. This lets it place single-clock glitches inside or outside the voting window and predict the exact clock at which each flag appears. It also aligns an overrun, a break or a status read against a completing frame on a known edge. The parity, 9-bit and interrupt-enable settings are all reached through control writes.

// File: rtl/serial_rx_pkg.sv
// Shared definitions for the serial receiver: register addresses, flag and
// control bit positions, and the receive state encoding.
package serial_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    localparam logic [1:0] A_STAT = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;

    localparam int NFLAG = 5;
    localparam int F_RDY = 4;
    localparam int F_OVR = 3;
    localparam int F_NF  = 2;
    localparam int F_FE  = 1;
    localparam int F_PE  = 0;

    localparam int C_RIE  = 0;
    localparam int C_PIE  = 1;
    localparam int C_PODD = 2;
    localparam int C_PEN  = 3;
    localparam int C_W9   = 5;
    localparam int C_TX9  = 6;
    localparam int C_RX9  = 7;

endpackage

// File: rtl/srx_sync.sv
// Multi-stage synchroniser for the asynchronous receive line.
// Assumes the line idles high; resets to all ones so no false start is seen.
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the line through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/srx_deframer.sv
// Frame assembler: detects the start edge on a tick, confirms it mid-bit,
// votes every bit from three centre samples, and emits a one-clock result
// pulse at the centre of the stop bit. Assumes OVS >= 8 and a synchronised line.
module srx_deframer
    import serial_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx,
    input  logic       w9,
    input  logic       pen,
    input  logic       podd,
    output logic       done_o,
    output logic [8:0] word_o,
    output logic       nf_o,
    output logic       fe_o,
    output logic       pe_o
);
    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2;

    rx_state_e   state;
    logic [CW-1:0] cnt;
    logic [3:0]  bidx;
    logic [8:0]  shreg;
    logic        s_a, s_b, nz, w9_q;
    logic        vote, odd, par;
    logic [3:0]  last_idx;

    // Majority vote and disagreement of the three centre samples.
    always_comb begin
        vote     = (s_a & s_b) | (s_a & rx) | (s_b & rx);
        odd      = !((s_a == s_b) && (s_b == rx));
        par      = ^shreg;
        last_idx = w9_q ? 4'd8 : 4'd7;
    end

    // Receive sequencer: tick counting, sampling and bit placement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            bidx   <= '0;
            shreg  <= '0;
            s_a    <= 1'b1;
            s_b    <= 1'b1;
            nz     <= 1'b0;
            w9_q   <= 1'b0;
            done_o <= 1'b0;
            word_o <= '0;
            nf_o   <= 1'b0;
            fe_o   <= 1'b0;
            pe_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (tick) begin
                if (state == ST_IDLE) begin
                    if (!rx) begin
                        state <= ST_START;
                        cnt   <= CW'(1);
                        nz    <= 1'b0;
                        w9_q  <= w9;
                        shreg <= '0;
                    end
                end else begin
                    cnt <= (cnt == CW'(OVS - 1)) ? '0 : cnt + 1'b1;
                    if (cnt == CW'(MID - 1)) s_a <= rx;
                    if (cnt == CW'(MID))     s_b <= rx;
                    if (cnt == CW'(MID + 1)) begin
                        nz <= nz | odd;
                        case (state)
                            ST_START: if (vote) state <= ST_IDLE;
                            ST_DATA:  shreg[bidx] <= vote;
                            ST_STOP: begin
                                done_o <= 1'b1;
                                word_o <= shreg;
                                fe_o   <= !vote;
                                nf_o   <= nz | odd;
                                pe_o   <= pen && (par != podd);
                                state  <= ST_IDLE;
                            end
                            default: ;
                        endcase
                    end
                    if (cnt == CW'(OVS - 1)) begin
                        case (state)
                            ST_START: begin
                                state <= ST_DATA;
                                bidx  <= '0;
                            end
                            ST_DATA: begin
                                if (bidx == last_idx) state <= ST_STOP;
                                else                  bidx  <= bidx + 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    // R2: the completion pulse lasts exactly one clock.
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: a start bit voted high returns the sequencer to idle.
    p_false_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && tick && cnt == CW'(MID + 1) && s_a && s_b && rx)
        |=> (state == ST_IDLE));

endmodule

// File: rtl/srx_regs.sv
// Register set: sticky status flags with a status-then-data clear sequence,
// the receive data holding register, the control register and the interrupt.
// Assumes one bus access per clock and combinational read data.
module srx_regs
    import serial_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr,
    input  logic       rd,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       done_i,
    input  logic [8:0] word_i,
    input  logic       nf_i,
    input  logic       fe_i,
    input  logic       pe_i,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       w9_o,
    output logic       pen_o,
    output logic       podd_o
);
    logic [NFLAG-1:0] flags_q, snap_q, set_v, clr_mask;
    logic             arm_q;
    logic [7:0]       data_q;
    logic             rx9_q, tx9_q, w9_q, pen_q, podd_q, pie_q, rie_q;
    logic             stat_rd, data_rd, ctrl_wr;
    logic             unused_bits;

    assign unused_bits = ^{wdata[C_RX9], wdata[4]};

    // Decode bus strobes and the flag set and clear vectors.
    always_comb begin
        stat_rd  = rd && (addr == A_STAT);
        data_rd  = rd && (addr == A_DATA);
        ctrl_wr  = wr && (addr == A_CTRL);
        clr_mask = (data_rd && arm_q) ? snap_q : '0;
        set_v    = '0;
        if (done_i) begin
            if (flags_q[F_RDY]) begin
                set_v[F_OVR] = 1'b1;
            end else begin
                set_v[F_RDY] = 1'b1;
                set_v[F_NF]  = nf_i;
                set_v[F_FE]  = fe_i;
                set_v[F_PE]  = pe_i;
            end
        end
    end

    // Flags, clear sequencing, data holding and control storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            snap_q  <= '0;
            arm_q   <= 1'b0;
            data_q  <= '0;
            rx9_q   <= 1'b0;
            tx9_q   <= 1'b0;
            w9_q    <= 1'b0;
            pen_q   <= 1'b0;
            podd_q  <= 1'b0;
            pie_q   <= 1'b0;
            rie_q   <= 1'b0;
        end else begin
            flags_q <= (flags_q & ~clr_mask) | set_v;
            if (stat_rd) begin
                snap_q <= flags_q;
                arm_q  <= 1'b1;
            end else if (data_rd) begin
                arm_q  <= 1'b0;
            end
            if (done_i && !flags_q[F_RDY]) begin
                data_q <= word_i[7:0];
                rx9_q  <= word_i[8];
            end
            if (ctrl_wr) begin
                tx9_q  <= wdata[C_TX9];
                w9_q   <= wdata[C_W9];
                pen_q  <= wdata[C_PEN];
                podd_q <= wdata[C_PODD];
                pie_q  <= wdata[C_PIE];
                rie_q  <= wdata[C_RIE];
            end
        end
    end

    // Read multiplexer and interrupt combination.
    always_comb begin
        case (addr)
            A_STAT:  rdata = {3'b000, flags_q};
            A_DATA:  rdata = data_q;
            A_CTRL:  rdata = {rx9_q, tx9_q, w9_q, 1'b0, pen_q, podd_q, pie_q, rie_q};
            default: rdata = 8'h00;
        endcase
        irq = (rie_q && (flags_q[F_RDY] || flags_q[F_OVR])) || (pie_q && flags_q[F_PE]);
    end

    assign w9_o   = w9_q;
    assign pen_o  = pen_q;
    assign podd_o = podd_q;

    // R8: a word arriving while ready is set leaves the data register alone.
    p_ovr_keeps_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && flags_q[F_RDY]) |=> $stable(data_q));

    // R8: a lost word never raises the framing flag.
    p_ovr_drops_fe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && flags_q[F_RDY] && !flags_q[F_FE]) |=> !flags_q[F_FE]);

    // R9: a data read that was not armed by a status read changes no flag.
    p_lone_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !arm_q && !done_i) |=> $stable(flags_q));

    // R7: software writes never reach the received ninth bit.
    p_rx9_readonly_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !done_i) |=> $stable(rx9_q));

endmodule

// File: rtl/serial_rx_top.sv
// Serial receiver top: synchroniser, frame assembler and register set.
// Assumes sample_tick pulses OVS times per bit period.
module serial_rx_top #(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_tick,
    input  logic       rxd,
    input  logic [1:0] bus_addr,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    logic       rx_s, done, nf, fe, pe, w9, pen, podd;
    logic [8:0] word;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
    );

    srx_deframer #(.OVS(OVS)) u_deframer (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick), .rx(rx_s),
        .w9(w9), .pen(pen), .podd(podd),
        .done_o(done), .word_o(word), .nf_o(nf), .fe_o(fe), .pe_o(pe)
    );

    srx_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
        .wdata(bus_wdata), .done_i(done), .word_i(word), .nf_i(nf), .fe_i(fe),
        .pe_i(pe), .rdata(bus_rdata), .irq(irq), .w9_o(w9), .pen_o(pen),
        .podd_o(podd)
    );

endmodule

// File: tb/tb_serial_rx_top.sv
// Cycle-by-cycle reference model of the receiver, compared on every clock.
module tb_serial_rx_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    serial_rx_top dut (
        .clk(clk), .rst_n(rst_n), .sample_tick(1'b1), .rxd(rxd),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    int    cyc = 0, n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // reference state
    bit m_rdy, m_ovr, m_nf, m_fe, m_pe, m_arm;
    bit [4:0] m_snap;
    bit [7:0] m_data;
    bit m_rx9, m_tx9, m_w9, m_pen, m_podd, m_pie, m_rie;
    // pending events
    int bus_kind = 0, bus_due = -1; bit [1:0] bus_a; bit [7:0] bus_d;
    bit ev_valid = 0; int ev_due; bit [8:0] ev_w; bit ev_nf, ev_fe, ev_pe;

    function automatic bit [7:0] exp_rd(input bit [1:0] a);
        case (a)
            2'd0: return {3'b000, m_rdy, m_ovr, m_nf, m_fe, m_pe};
            2'd1: return m_data;
            2'd2: return {m_rx9, m_tx9, m_w9, 1'b0, m_pen, m_podd, m_pie, m_rie};
            default: return 8'h00;
        endcase
    endfunction

    // Advance the model one clock and compare outputs.
    always @(posedge clk) begin
        #5;
        cyc++;
        if (rst_n && !finished) begin
            if (bus_due == cyc) begin
                if (bus_kind == 1) begin
                    m_snap = {m_rdy, m_ovr, m_nf, m_fe, m_pe}; m_arm = 1;
                end else if (bus_kind == 2) begin
                    if (m_arm) begin
                        if (m_snap[4]) m_rdy = 0;
                        if (m_snap[3]) m_ovr = 0;
                        if (m_snap[2]) m_nf = 0;
                        if (m_snap[1]) m_fe = 0;
                        if (m_snap[0]) m_pe = 0;
                    end
                    m_arm = 0;
                end else if (bus_kind == 3 && bus_a == 2'd2) begin
                    m_tx9 = bus_d[6]; m_w9 = bus_d[5]; m_pen = bus_d[3];
                    m_podd = bus_d[2]; m_pie = bus_d[1]; m_rie = bus_d[0];
                end
                bus_kind = 0;
            end
            if (ev_valid && ev_due == cyc) begin
                ev_valid = 0;
                if (m_rdy) m_ovr = 1;
                else begin
                    m_data = ev_w[7:0]; m_rx9 = ev_w[8]; m_rdy = 1;
                    m_nf |= ev_nf; m_fe |= ev_fe; m_pe |= ev_pe;
                end
            end
            n_chk++;
            if (bus_rdata !== exp_rd(bus_addr)) begin
                n_fail++;
                $display("FAIL %s: rdata=%h expected %h (addr %0d, cycle %0d)",
                         cur_req, bus_rdata, exp_rd(bus_addr), bus_addr, cyc);
            end
            n_chk++;
            if (irq !== ((m_rie && (m_rdy || m_ovr)) || (m_pie && m_pe))) begin
                n_fail++;
                $display("FAIL %s: irq=%b expected %b (cycle %0d)", cur_req, irq,
                         (m_rie && (m_rdy || m_ovr)) || (m_pie && m_pe), cyc);
            end
        end
    end

    task automatic bus_op(input int kind, input bit [1:0] a, input bit [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d;
        bus_rd = (kind != 3); bus_wr = (kind == 3);
        bus_kind = kind; bus_a = a; bus_d = d; bus_due = cyc + 1;
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; bus_addr = 2'd0;
    endtask

    task automatic clear_seq();
        bus_op(1, 2'd0, 8'h00);
        bus_op(2, 2'd1, 8'h00);
    endtask

    // Build a frame as a per-clock level queue, decode it, then drive it.
    task automatic send(input bit [8:0] w, input bit stp, input int gl);
        bit q[$]; int nb, s; bit a, b2, c, v, nz, fe, ok; bit [8:0] wd;
        nb = m_w9 ? 9 : 8; s = nb + 1;
        for (int i = 0; i < 16; i++) q.push_back(1'b0);
        for (int b = 0; b < nb; b++) for (int i = 0; i < 16; i++) q.push_back(w[b]);
        for (int i = 0; i < 16; i++) q.push_back(stp);
        for (int i = 0; i < 24; i++) q.push_back(1'b1);
        if (gl >= 0) q[gl] = ~q[gl];
        nz = 0; wd = '0; fe = 0; ok = 1;
        for (int b = 0; b <= s; b++) begin
            a = q[16*b+7]; b2 = q[16*b+8]; c = q[16*b+9];
            v = (a & b2) | (a & c) | (b2 & c);
            if (!(a == b2 && b2 == c)) nz = 1;
            if (b == 0) begin if (v) ok = 0; end
            else if (b <= nb) wd[b-1] = v;
            else fe = !v;
        end
        for (int i = 0; i < q.size(); i++) begin
            @(negedge clk);
            rxd = q[i];
            if (i == 0 && ok) begin
                ev_valid = 1; ev_due = cyc + 16*s + 13; ev_w = wd;
                ev_nf = nz; ev_fe = fe; ev_pe = m_pen && ((^wd) != m_podd);
            end
        end
    endtask

    task automatic false_start(input int low_len);
        for (int i = 0; i < low_len; i++) begin @(negedge clk); rxd = 0; end
        for (int i = 0; i < 40; i++) begin @(negedge clk); rxd = 1; end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete (cycle %0d)", cyc);
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        cur_req = "R1"; repeat (4) @(negedge clk);
        bus_op(1, 2'd2, 8'h00);            // R1: control reads zero
        // R11: write map and read-only bits
        cur_req = "R11";
        bus_op(3, 2'd2, 8'hD1);
        bus_op(3, 2'd0, 8'hFF);
        bus_op(3, 2'd1, 8'hFF);
        bus_op(3, 2'd3, 8'hFF);
        bus_op(1, 2'd3, 8'h00);
        bus_op(1, 2'd2, 8'h00);
        // R2: plain 8-bit frame
        cur_req = "R2";
        send(9'h0A5, 1'b1, -1);
        bus_op(2, 2'd1, 8'h00);
        // R9: lone data read keeps flags, then full sequence clears
        cur_req = "R9";
        bus_op(2, 2'd1, 8'h00);
        clear_seq();
        send(9'h03C, 1'b1, -1);
        bus_op(2, 2'd1, 8'h00);
        clear_seq();
        // R9: flag set between status read and data read survives
        send(9'h055, 1'b1, -1);
        bus_op(1, 2'd0, 8'h00);
        send(9'h066, 1'b1, -1);
        bus_op(2, 2'd1, 8'h00);
        clear_seq();
        // R8: overrun with a bad stop bit keeps old word, no framing flag
        cur_req = "R8";
        send(9'h011, 1'b1, -1);
        send(9'h022, 1'b0, -1);
        bus_op(1, 2'd1, 8'h00);
        clear_seq();
        // R3: glitch inside voting window, then outside it
        cur_req = "R3";
        send(9'h00F, 1'b1, 16*3+8);
        clear_seq();
        send(9'h0F0, 1'b1, 16*2+2);
        clear_seq();
        send(9'h0C3, 1'b1, 16*9+7);
        clear_seq();
        // R4: short low pulse is rejected
        cur_req = "R4";
        false_start(6);
        bus_op(1, 2'd1, 8'h00);
        // R5: bad stop bit and break frame
        cur_req = "R5";
        send(9'h081, 1'b0, -1);
        clear_seq();
        send(9'h000, 1'b0, -1);
        clear_seq();
        // R6: even parity ok and error, odd parity, disabled
        cur_req = "R6";
        bus_op(3, 2'd2, 8'h0A);
        send(9'h003, 1'b1, -1);
        clear_seq();
        send(9'h007, 1'b1, -1);
        clear_seq();
        bus_op(3, 2'd2, 8'h0E);
        send(9'h007, 1'b1, -1);
        clear_seq();
        send(9'h003, 1'b1, -1);
        clear_seq();
        bus_op(3, 2'd2, 8'h02);
        send(9'h007, 1'b1, -1);
        clear_seq();
        // R7: 9-bit words, ninth bit in control bit 7
        cur_req = "R7";
        bus_op(3, 2'd2, 8'h61);
        send(9'h1C3, 1'b1, -1);
        bus_op(1, 2'd2, 8'h00);
        clear_seq();
        send(9'h042, 1'b1, -1);
        bus_op(1, 2'd2, 8'h00);
        clear_seq();
        // R10: enables off, noise and framing raise no interrupt
        cur_req = "R10";
        bus_op(3, 2'd2, 8'h00);
        send(9'h0AA, 1'b0, 16*4+8);
        clear_seq();
        bus_op(3, 2'd2, 8'h01);
        send(9'h011, 1'b1, -1);
        send(9'h012, 1'b1, -1);
        clear_seq();
        clear_seq();
        repeat (4) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule